// File: doc/BRIEF.md
# SPI Byte Controller with Buffered Receive

This block connects a small register bus to a four-wire serial link and moves data one byte at a time. It can act as master or as slave. It has three registers. A control register at address 0 selects the role, the bit order and the clock rate. A status register at address 1 holds the flags. A data register at address 2 is used for both writes and reads. Writing the data register loads the byte straight into the shift register, because transmit has no second buffer. In master mode that same write starts an exchange.

Receive has two stages. When a byte completes, it moves from the shifter into a holding buffer, and bus reads of the data register return that buffer. Three flags report events: byte complete, write collision and overrun. They are cleared by reading the status register and then accessing the data register. If a byte completes while the previous one is still unacknowledged, the newer byte is dropped and the older one stays readable. The byte-complete flag is also presented as a level interrupt output.

On the serial side, the clock idles low. Data changes on the rising clock edge and is sampled on the falling edge. As master, the block drives the clock, data out and an active-low select. As slave, it takes in clock, data and select through synchronisers and drives its data output.

Top module: `spi_byte_ctrl`

## Requirements
- R1: After reset, all three registers read 0, `sck_o` is low, `ss_no` is high, `irq_o` is low and `miso_o` is low.
- R2: In master mode (control bit 0 = 1), a data write while idle drives `ss_no` low. The block then produces exactly 8 `sck_o` pulses and raises `ss_no` again after the 8th falling edge.
- R3: Control bits [3:2] set the `sck_o` period in system clocks: 0 gives 2, 1 gives 4, 2 gives 16, 3 gives 32.
- R4: Control bit 1 = 0 shifts most-significant bit first and 1 shifts least-significant bit first. This applies to sent and received bits, in both roles.
- R5: Serial data out changes only on a rising `sck_o` edge and input is sampled on the falling edge. `sck_o` is low whenever `ss_no` is high.
- R6: At the end of every byte, in either role, status bit 7 (byte done) sets and `irq_o` goes high.
- R7: A read of address 2 returns the holding buffer. The buffer is loaded with the received byte when that byte completes.
- R8: The status flags clear only after a status read (address 1) taken while a flag is set, followed by an access to address 2. An address-2 access on its own clears nothing.
- R9: If a byte completes while byte done is still set, status bit 5 (overrun) sets, the new byte is dropped and the buffer keeps the older byte. The R8 sequence clears overrun, and later bytes load the buffer again.
- R10: A data write while a byte is in progress (master busy, or slave with `ss_ni` low) leaves the shifter unchanged and sets status bit 6 (collision).
- R11: In slave mode, a data write with `ss_ni` high preloads the shifter and does not start a transfer. Bits shift only while `ss_ni` is low. Raising `ss_ni` mid-byte aborts that byte without setting byte done.
- R12: In slave mode, `sck_o` stays low, `ss_no` stays high and `mosi_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address: 0 control, 1 status, 2 data |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for the addressed register |
| irq_o | output | 1 | Byte-done level interrupt |
| sck_o | output | 1 | Serial clock out (master) |
| mosi_o | output | 1 | Serial data out (master) |
| ss_no | output | 1 | Select out, active low (master) |
| miso_i | input | 1 | Serial data in (master) |
| sck_i | input | 1 | Serial clock in (slave) |
| mosi_i | input | 1 | Serial data in (slave) |
| ss_ni | input | 1 | Select in, active low (slave) |
| miso_o | output | 1 | Serial data out (slave) |

## Verification
The assertions check the following on every cycle:
- the serial clock stays low while select is high;
- master data out changes only on a rising clock edge;
- master select rises only at byte completion, and the interrupt rises only then too;
- the holding buffer does not change when overrun sets;
- collision sets only after a data write made while busy;
- the master pins stay quiet in slave mode.

Some behaviour only the directed scenarios can show:
- the clock period for each rate code;
- the bit order in both directions;
- the value returned from the holding buffer;
- that a data access alone does not clear the flags;
- that an aborted slave byte leaves byte done clear and the next byte is received intact.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;
  localparam int HALF_W = 5;

  typedef struct packed {
    logic [1:0] rate;
    logic       lsb_first;
    logic       master;
  } ctrl_t;

  // half sck period in system clocks per rate code
  function automatic logic [HALF_W-1:0] half_period(input logic [1:0] rate);
    case (rate)
      2'd0:    half_period = HALF_W'(1);
      2'd1:    half_period = HALF_W'(2);
      2'd2:    half_period = HALF_W'(8);
      default: half_period = HALF_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div
  import spi_byte_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] rate_i,
  output logic       sck_o,
  output logic       lead_o,
  output logic       trail_o
);
  logic [HALF_W-1:0] cnt_q;
  logic              tick;

  assign tick    = run_i && (cnt_q == half_period(rate_i) - HALF_W'(1));
  assign lead_o  = tick && !sck_o;
  assign trail_o = tick && sck_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_o <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      sck_o <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      sck_o <= ~sck_o;
    end else begin
      cnt_q <= cnt_q + HALF_W'(1);
    end
  end
endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] load_data_i,
  input  logic          lead_i,
  input  logic          trail_i,
  input  logic          abort_i,
  input  logic          lsb_first_i,
  input  logic          din_i,
  output logic          dout_o,
  output logic          done_o,
  output logic [DW-1:0] rx_o
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] sr_q, sr_nx;
  logic [CW-1:0] cnt_q;

  assign sr_nx  = lsb_first_i ? {din_i, sr_q[DW-1:1]} : {sr_q[DW-2:0], din_i};
  assign done_o = trail_i && (cnt_q == CW'(DW - 1));
  assign rx_o   = sr_nx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      dout_o <= 1'b0;
    end else begin
      if (load_i) begin
        sr_q  <= load_data_i;
        cnt_q <= '0;
      end else if (abort_i) begin
        cnt_q <= '0;
      end else if (trail_i) begin
        sr_q  <= sr_nx;
        cnt_q <= done_o ? '0 : cnt_q + CW'(1);
      end
      if (lead_i) dout_o <= lsb_first_i ? sr_q[0] : sr_q[DW-1];
    end
  end
endmodule

// File: rtl/spi_status.sv
module spi_status #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  logic [DW-1:0] rx_i,
  input  logic          stat_rd_i,
  input  logic          data_acc_i,
  input  logic          wcol_set_i,
  output logic          spif_o,
  output logic          wcol_o,
  output logic          ovr_o,
  output logic [DW-1:0] buf_o
);
  logic arm_q, clr, spif_eff, ovr_eff, wcol_eff, drop;

  assign clr      = data_acc_i && arm_q;
  assign spif_eff = spif_o && !clr;
  assign ovr_eff  = ovr_o && !clr;
  assign wcol_eff = wcol_o && !clr;
  assign drop     = spif_eff || ovr_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q  <= 1'b0;
      spif_o <= 1'b0;
      wcol_o <= 1'b0;
      ovr_o  <= 1'b0;
      buf_o  <= '0;
    end else begin
      if (stat_rd_i && (spif_o || wcol_o || ovr_o)) arm_q <= 1'b1;
      else if (data_acc_i)                          arm_q <= 1'b0;
      spif_o <= spif_eff || done_i;
      ovr_o  <= ovr_eff || (done_i && drop);
      wcol_o <= wcol_eff || wcol_set_i;
      if (done_i && !drop) buf_o <= rx_i;
    end
  end
endmodule

// File: rtl/spi_byte_ctrl.sv
module spi_byte_ctrl
  import spi_byte_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic          sck_o,
  output logic          mosi_o,
  output logic          ss_no,
  input  logic          miso_i,
  input  logic          sck_i,
  input  logic          mosi_i,
  input  logic          ss_ni,
  output logic          miso_o
);
  ctrl_t         ctrl_q;
  logic          busy_q, busy_any, ss_act;
  logic [2:0]    sck_sy, ss_sy;
  logic [1:0]    mosi_sy;
  logic          data_wr, data_acc, stat_rd, start, load, wcol_set;
  logic          m_sck, m_lead, m_trail, s_lead, s_trail, s_abort;
  logic          lead, trail, din, dout, done;
  logic          spif, wcol, ovr;
  logic [DW-1:0] rx_byte, rx_buf;

  assign data_wr  = wr_i && (addr_i == A_DATA);
  assign data_acc = (wr_i || rd_i) && (addr_i == A_DATA);
  assign stat_rd  = rd_i && (addr_i == A_STAT);

  // slave inputs: two-stage sync plus one edge stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_sy  <= '0;
      ss_sy   <= '1;
      mosi_sy <= '0;
    end else begin
      sck_sy  <= {sck_sy[1:0], sck_i};
      ss_sy   <= {ss_sy[1:0], ss_ni};
      mosi_sy <= {mosi_sy[0], mosi_i};
    end
  end

  assign ss_act   = !ss_sy[1];
  assign s_lead   = ss_act && sck_sy[1] && !sck_sy[2];
  assign s_trail  = ss_act && !sck_sy[1] && sck_sy[2];
  assign s_abort  = !ctrl_q.master && ss_sy[1] && !ss_sy[2];

  assign busy_any = ctrl_q.master ? busy_q : ss_act;
  assign start    = data_wr && ctrl_q.master && !busy_q;
  assign load     = data_wr && !busy_any;
  assign wcol_set = data_wr && busy_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      busy_q <= 1'b0;
    end else begin
      if (wr_i && addr_i == A_CTRL) ctrl_q <= ctrl_t'(wdata_i[3:0]);
      if (!ctrl_q.master) busy_q <= 1'b0;
      else if (start)     busy_q <= 1'b1;
      else if (done)      busy_q <= 1'b0;
    end
  end

  spi_clk_div u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (busy_q && ctrl_q.master),
    .rate_i  (ctrl_q.rate),
    .sck_o   (m_sck),
    .lead_o  (m_lead),
    .trail_o (m_trail)
  );

  assign lead  = ctrl_q.master ? m_lead  : s_lead;
  assign trail = ctrl_q.master ? m_trail : s_trail;
  assign din   = ctrl_q.master ? miso_i  : mosi_sy[1];

  spi_shift #(.DW(DW)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_data_i (wdata_i),
    .lead_i      (lead),
    .trail_i     (trail),
    .abort_i     (s_abort),
    .lsb_first_i (ctrl_q.lsb_first),
    .din_i       (din),
    .dout_o      (dout),
    .done_o      (done),
    .rx_o        (rx_byte)
  );

  spi_status #(.DW(DW)) u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (done),
    .rx_i       (rx_byte),
    .stat_rd_i  (stat_rd),
    .data_acc_i (data_acc),
    .wcol_set_i (wcol_set),
    .spif_o     (spif),
    .wcol_o     (wcol),
    .ovr_o      (ovr),
    .buf_o      (rx_buf)
  );

  assign irq_o  = spif;
  assign sck_o  = m_sck && ctrl_q.master;
  assign ss_no  = !(busy_q && ctrl_q.master);
  assign mosi_o = ctrl_q.master && dout;
  assign miso_o = !ctrl_q.master && ss_act && dout;

  always_comb begin
    case (addr_i)
      A_CTRL:  rdata_o = {{(DW-4){1'b0}}, ctrl_q};
      A_STAT:  rdata_o = {spif, wcol, ovr, {(DW-3){1'b0}}};
      A_DATA:  rdata_o = rx_buf;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/spi_byte_ctrl_chk.sv
module spi_byte_ctrl_chk
  import spi_byte_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          master_i,
  input logic          sck_o,
  input logic          ss_no,
  input logic          mosi_o,
  input logic          irq_o,
  input logic          done_i,
  input logic          ovr_i,
  input logic          wcol_i,
  input logic [DW-1:0] buf_i,
  input logic          busy_i,
  input logic          wr_i,
  input logic [1:0]    addr_i
);
  assert_idle_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_no |-> !sck_o);

  assert_mosi_on_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && $past(master_i) && $changed(mosi_o)) |-> $rose(sck_o));

  assert_ss_end_on_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && $rose(ss_no)) |-> $past(done_i));

  assert_irq_on_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(done_i));

  assert_ovr_keeps_buf_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_i) |-> $stable(buf_i));

  assert_wcol_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wcol_i) |-> $past(wr_i && addr_i == A_DATA && busy_i));

  assert_slave_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> (ss_no && !sck_o && !mosi_o));
endmodule

bind spi_byte_ctrl spi_byte_ctrl_chk #(.DW(DW)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .master_i (ctrl_q.master),
  .sck_o    (sck_o),
  .ss_no    (ss_no),
  .mosi_o   (mosi_o),
  .irq_o    (irq_o),
  .done_i   (done),
  .ovr_i    (ovr),
  .wcol_i   (wcol),
  .buf_i    (rx_buf),
  .busy_i   (busy_any),
  .wr_i     (wr_i),
  .addr_i   (addr_i)
);

// File: tb/spi_byte_ctrl_tb_top.sv
`timescale 1ns/1ps
module spi_byte_ctrl_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] addr_i = '0;
  logic       wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o, sck_o, mosi_o, ss_no, miso_o;
  logic       miso_i = 1'b0, sck_i = 1'b0, mosi_i = 1'b0, ss_ni = 1'b1;
  int         n_chk = 0, n_err = 0;
  bit         ended = 1'b0;

  always #5 clk_i = ~clk_i;

  spi_byte_ctrl dut_i (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i); addr_i = a; rd_i = 1'b1; #1 d = rdata_o;
    @(negedge clk_i); rd_i = 1'b0;
  endtask

  function automatic int divisor(input logic [1:0] r);
    case (r) 2'd0: return 2; 2'd1: return 4; 2'd2: return 16; default: return 32; endcase
  endfunction

  // master exchange with a bench slave on miso_i; records mosi bits and pulse spacing
  task automatic master_xfer(input logic [1:0] rate, input bit lsb, input logic [7:0] tx,
                             input logic [7:0] sb, input bit collide,
                             output logic [7:0] seen, output int pulses, output bit per_ok);
    int cyc = 0, last = 0; logic prev = 1'b0;
    pulses = 0; per_ok = 1'b1; seen = '0;
    bus_wr(2'd0, {4'b0, rate, lsb, 1'b1});
    bus_wr(2'd2, tx);
    if (collide) bus_wr(2'd2, ~tx);
    while (!ss_no && cyc < 4000) begin
      @(negedge clk_i); cyc++;
      if (sck_o && !prev) begin
        seen[lsb ? pulses : 7 - pulses] = mosi_o;
        miso_i = lsb ? sb[pulses] : sb[7 - pulses];
        if (pulses > 0 && (cyc - last) != divisor(rate)) per_ok = 1'b0;
        last = cyc; pulses++;
      end
      prev = sck_o;
    end
    check(ss_no && !sck_o, "R2 select released, clock low", {ss_no, sck_o}, 2);
  endtask

  task automatic slave_bits(input logic [7:0] mb, input int n, input bit lsb, output logic [7:0] seen);
    seen = '0;
    for (int k = 0; k < n; k++) begin
      sck_i = 1'b1; mosi_i = lsb ? mb[k] : mb[7 - k];
      repeat (6) @(negedge clk_i);
      seen[lsb ? k : 7 - k] = miso_o;
      sck_i = 1'b0;
      repeat (6) @(negedge clk_i);
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check(!sck_o && ss_no && !irq_o && !miso_o, "R1 pins at reset", {sck_o, ss_no, irq_o, miso_o}, 4'b0100);
    bus_rd(2'd0, d); check(d == 8'h00, "R1 control reset", d, 0);
    bus_rd(2'd1, d); check(d == 8'h00, "R1 status reset", d, 0);
    bus_rd(2'd2, d); check(d == 8'h00, "R1 data reset", d, 0);
  endtask

  task automatic t_master_basic;
    logic [7:0] seen, d; int p; bit ok;
    master_xfer(2'd0, 1'b0, 8'hA5, 8'h3C, 1'b0, seen, p, ok);
    check(p == 8, "R2 eight pulses", p, 8);
    check(ok, "R3 divide by 2", ok, 1);
    check(seen == 8'hA5, "R4 msb-first out", seen, 8'hA5);
    check(irq_o, "R6 irq after master byte", irq_o, 1);
    bus_rd(2'd2, d); check(d == 8'h3C, "R7 holding buffer", d, 8'h3C);
    @(negedge clk_i);
    check(irq_o, "R8 data read alone keeps flag", irq_o, 1);
    bus_rd(2'd1, d); check(d == 8'h80, "R6 status byte done", d, 8'h80);
    bus_rd(2'd2, d);
    @(negedge clk_i);
    check(!irq_o, "R8 flag cleared by sequence", irq_o, 0);
  endtask

  task automatic t_master_rates;
    logic [7:0] seen, d, tx, sb; int p; bit ok;
    for (int r = 1; r < 4; r++) begin
      tx = 8'h1E ^ 8'(r * 37); sb = 8'hC8 ^ 8'(r * 11);
      master_xfer(2'(r), r[0], tx, sb, 1'b0, seen, p, ok);
      check(ok && p == 8, "R3 sck period for rate code", r, divisor(2'(r)));
      check(seen == tx, "R4 bit order out", seen, tx);
      bus_rd(2'd1, d); bus_rd(2'd2, d);
      check(d == sb, "R4 bit order in", d, sb);
    end
  endtask

  task automatic t_collision;
    logic [7:0] seen, d; int p; bit ok;
    master_xfer(2'd3, 1'b0, 8'h69, 8'h5E, 1'b1, seen, p, ok);
    check(seen == 8'h69, "R10 busy write ignored", seen, 8'h69);
    bus_rd(2'd1, d); check(d == 8'hC0, "R10 collision flag", d, 8'hC0);
    bus_rd(2'd2, d); check(d == 8'h5E, "R10 receive unaffected", d, 8'h5E);
    bus_rd(2'd1, d); check(d == 8'h00, "R8 all flags cleared", d, 0);
  endtask

  task automatic t_overrun;
    logic [7:0] seen, d; int p; bit ok;
    master_xfer(2'd0, 1'b0, 8'h01, 8'h11, 1'b0, seen, p, ok);
    master_xfer(2'd0, 1'b0, 8'h02, 8'h22, 1'b0, seen, p, ok);
    bus_rd(2'd1, d); check(d == 8'hA0, "R9 overrun flag", d, 8'hA0);
    bus_rd(2'd2, d); check(d == 8'h11, "R9 older byte kept", d, 8'h11);
    bus_rd(2'd1, d); check(d == 8'h00, "R9 overrun cleared", d, 0);
    master_xfer(2'd1, 1'b0, 8'h03, 8'h33, 1'b0, seen, p, ok);
    bus_rd(2'd1, d); bus_rd(2'd2, d);
    check(d == 8'h33, "R9 buffer loads after clear", d, 8'h33);
  endtask

  task automatic t_slave;
    logic [7:0] seen, d;
    bus_wr(2'd0, 8'h00);
    bus_wr(2'd2, 8'h96);
    check(!irq_o && ss_no && !sck_o, "R11 preload starts nothing", {irq_o, ss_no, sck_o}, 3'b010);
    ss_ni = 1'b0; repeat (4) @(negedge clk_i);
    bus_wr(2'd2, 8'hFF);
    slave_bits(8'h4B, 8, 1'b0, seen);
    ss_ni = 1'b1; repeat (4) @(negedge clk_i);
    check(seen == 8'h96, "R11 preload shifted out, R10 busy write ignored", seen, 8'h96);
    check(irq_o, "R6 irq after slave byte", irq_o, 1);
    check(ss_no && !sck_o && !mosi_o, "R12 master pins quiet", {ss_no, sck_o, mosi_o}, 3'b100);
    bus_rd(2'd1, d); check(d == 8'hC0, "R10 slave collision", d, 8'hC0);
    bus_rd(2'd2, d); check(d == 8'h4B, "R7 slave received byte", d, 8'h4B);
  endtask

  task automatic t_slave_abort;
    logic [7:0] seen, d;
    bus_wr(2'd0, 8'h02);
    for (int k = 0; k < 3; k++) begin
      sck_i = 1'b1; repeat (6) @(negedge clk_i); sck_i = 1'b0; repeat (6) @(negedge clk_i);
    end
    ss_ni = 1'b0; repeat (4) @(negedge clk_i);
    slave_bits(8'hFF, 3, 1'b1, seen);
    ss_ni = 1'b1; repeat (6) @(negedge clk_i);
    check(!irq_o, "R11 aborted byte sets no flag", irq_o, 0);
    bus_wr(2'd2, 8'h5A);
    ss_ni = 1'b0; repeat (4) @(negedge clk_i);
    slave_bits(8'h6D, 8, 1'b1, seen);
    ss_ni = 1'b1; repeat (4) @(negedge clk_i);
    check(irq_o, "R11 full byte after abort", irq_o, 1);
    check(seen == 8'h5A, "R4 slave lsb-first out", seen, 8'h5A);
    bus_rd(2'd1, d); bus_rd(2'd2, d);
    check(d == 8'h6D, "R4 slave lsb-first in", d, 8'h6D);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_master_basic();
    t_master_rates();
    t_collision();
    t_overrun();
    t_slave();
    t_slave_abort();
    if (!ended) begin
      ended = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!ended) begin
      ended = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule